// File: doc/BRIEF.md
# Bus-Snooping Ones-Complement Checksum Unit

This block sits beside a 32-bit data bus and watches transfers, whether a DMA engine or programmed I/O moves them. While its enable bit is set, every word seen on the bus is captured into an input latch. On the next clock that word is added into two independent 16-bit ones-complement accumulators: one covers the upper half-words of the stream and the other covers the lower half-words. Each accumulator is a ring of short lookahead groups that are 3 or 2 bits wide. A registered carry sits between neighbouring groups, and the carry out of the top group feeds back into bit 0 of the same half. This keeps the logic depth per clock down to one small group, and it still accepts a new word every cycle.

Software sees two locations. Location 0 is a control word whose bit 0 is the enable. Location 1 is the checksum location: a read returns the raw pair of partial sums as {upper, lower}, and a write of any value clears the sums, the pending carries and the input latch. There is no load operation. A starting value is seeded by clearing the unit and then passing that value across the bus as one transfer. The block also folds the two halves in hardware into a finished 16-bit Internet checksum. A ready flag tells software when the carry ring has emptied and both results can be trusted.

Top module: `cks_snoop_top`

## Requirements
- R1: The value read at location 1 is {upper sum, lower sum}. Each half is the ones-complement sum of the matching 16-bit halves of the accumulated words, and no carry passes between the halves.
- R2: The carry out of bit 15 of each half wraps into bit 0 of the same half. For example, 0xFFFF plus 0x0001 settles to 0x0001.
- R3: A write of any value to location 1 zeroes both sums, all pending carries and the input latch. A bus word in the same cycle is dropped, and sum_ready is low in the cycle after the write.
- R4: Bit 0 of location 0 is the enable, and a read of location 0 returns it in bit 0. While the enable is 0, bus transfers leave the sums unchanged.
- R5: Valid bus words on consecutive clocks are all accumulated, one per cycle.
- R6: Take a bus word captured at clock edge k. sum_ready stays low after each of the edges k through k+5.
- R7: sum_ready goes high again only when no word is pending, the 5-cycle drain count has run out and no carry register is set. From then on the raw sums and the checksum are final, and sum_ready rises within 20 cycles of the last capture.
- R8: csum_out is the bitwise inverse of the end-around ones-complement sum of the two halves. It equals the Internet checksum of all accumulated 16-bit half-words.
- R9: Reading either location does not change the sums, and the sums hold steady while the unit is ready and idle.
- R10: Clearing and then accumulating a seed word followed by data gives the same result as accumulating the seed as ordinary data.
- R11: Accumulating the data again together with its checksum (as the word {16'h0, csum}) yields csum_out equal to 0x0000.
- R12: After reset, both sums read 0, the enable reads 0, sum_ready is 1 and csum_out is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_vld | input | 1 | A transfer is on the snooped bus this cycle |
| bus_data | input | 32 | Snooped bus word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 checksum location |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| csum_out | output | 16 | Finished Internet checksum |
| sum_ready | output | 1 | Carry ring drained, results final |

## Verification
The bench targets the end-around carry: a word of all ones followed by ones in each half must settle to 0x0001. A design that dropped the wrap would read zero, and one that let the carry cross halves would corrupt the other sum. It also checks that a clear in the same cycle as a bus word leaves zero. A design that let the word win would show residue after the clear. The bench checks that ready stays low for the full drain window, because a design that raised it early would expose a sum with carries still in flight. Random packets with gaps and back-to-back words are compared with an Internet checksum reference, and re-summing each packet with its checksum must give zero. A slip in fold or inversion therefore shows up on every packet.

// File: rtl/cks_pkg.sv
package cks_pkg;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_SUM  = 1'b1;

    // Lookahead groups repeat a 3,3,2 bit pattern every 8 bits.
    // Returns the low bit index of group g; grp_lo(NGRP) is the half width.
    function automatic int grp_lo(input int g);
        int base;
        int rem;
        base = 8 * (g / 3);
        rem  = g % 3;
        if (rem == 0)      return base;
        else if (rem == 1) return base + 3;
        else               return base + 6;
    endfunction

endpackage

// File: rtl/cks_ring_half.sv
module cks_ring_half
    import cks_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int NGRP  = (HALF_W / 8) * 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [HALF_W-1:0] addend,
    output logic [HALF_W-1:0] acc_q,
    output logic              busy
);

    typedef struct packed {
        logic [HALF_W-1:0] acc;
        logic [NGRP-1:0]   cy;
    } ring_t;

    ring_t r_d, r_q;
    logic [HALF_W-1:0] acc_nx;
    logic [NGRP-1:0]   cy_nx;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO   = grp_lo(g);
        localparam int W    = grp_lo(g + 1) - LO;
        localparam int PREV = (g == 0) ? NGRP - 1 : g - 1;
        logic [W:0] part;
        always_comb begin
            part = {1'b0, r_q.acc[LO +: W]} + {1'b0, addend[LO +: W]}
                 + {{W{1'b0}}, r_q.cy[PREV]};
        end
        assign acc_nx[LO +: W] = part[W-1:0];
        assign cy_nx[g]        = part[W];
    end

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.acc = '0;
            r_d.cy  = '0;
        end else begin
            r_d.acc = acc_nx;
            r_d.cy  = cy_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign acc_q = r_q.acc;
    assign busy  = |r_q.cy;

    // R7: with nothing to add and no carry in flight the ring holds its value
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && addend == '0 && !busy) |=> $stable(acc_q));

endmodule

// File: rtl/cks_fold.sv
module cks_fold #(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0] hi,
    input  logic [HALF_W-1:0] lo,
    output logic [HALF_W-1:0] csum
);

    logic [HALF_W:0]   raw;
    logic [HALF_W-1:0] wrapped;

    always_comb begin
        raw     = {1'b0, hi} + {1'b0, lo};
        wrapped = raw[HALF_W-1:0] + {{(HALF_W-1){1'b0}}, raw[HALF_W]};
        csum    = ~wrapped;
    end

endmodule

// File: rtl/cks_regif.sv
module cks_regif
    import cks_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              addr,
    input  logic              wbit,
    input  logic [DATA_W-1:0] sum_raw,
    output logic              en,
    output logic              clr,
    output logic [DATA_W-1:0] rdata
);

    logic en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (wr && addr == ADDR_CTRL) en_d = wbit;
        clr   = wr && addr == ADDR_SUM;
        rdata = (addr == ADDR_SUM) ? sum_raw : {{(DATA_W-1){1'b0}}, en_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign en = en_q;

    // R4: a control write sets the enable to the written bit 0
    a_r4_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_CTRL) |=> (en == $past(wbit)));

endmodule

// File: rtl/cks_snoop_top.sv
module cks_snoop_top
    import cks_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int DRAIN_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_vld,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W/2-1:0] csum_out,
    output logic              sum_ready
);

    localparam int HALF_W = DATA_W / 2;
    localparam int CNT_W  = $clog2(DRAIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DRAIN_CYC);

    typedef struct packed {
        logic [DATA_W-1:0] lat;
        logic              lat_v;
        logic [CNT_W-1:0]  cnt;
    } st_t;

    st_t st_d, st_q;
    logic en, clr, cap;
    logic [DATA_W-1:0] sum_raw;
    logic [1:0] busy;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:1];

    cks_regif #(.DATA_W(DATA_W)) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wbit    (reg_wdata[0]),
        .sum_raw (sum_raw),
        .en      (en),
        .clr     (clr),
        .rdata   (reg_rdata)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        cks_ring_half #(.HALF_W(HALF_W)) u_ring (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .addend (st_q.lat[h*HALF_W +: HALF_W]),
            .acc_q  (sum_raw[h*HALF_W +: HALF_W]),
            .busy   (busy[h])
        );
    end

    cks_fold #(.HALF_W(HALF_W)) u_fold (
        .hi   (sum_raw[DATA_W-1:HALF_W]),
        .lo   (sum_raw[HALF_W-1:0]),
        .csum (csum_out)
    );

    always_comb begin
        cap  = bus_vld && en && !clr;
        st_d = st_q;
        if (clr) begin
            st_d.lat   = '0;
            st_d.lat_v = 1'b0;
            st_d.cnt   = '0;
        end else begin
            st_d.lat   = cap ? bus_data : '0;
            st_d.lat_v = cap;
            if (cap)
                st_d.cnt = '0;
            else if (!st_q.lat_v && st_q.cnt != CNT_FULL)
                st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lat   <= '0;
            st_q.lat_v <= 1'b0;
            st_q.cnt   <= CNT_FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_ready = !st_q.lat_v && st_q.cnt == CNT_FULL && busy == 2'b00;

    // R3: a clear leaves both sums at zero and drops readiness
    a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum_raw == '0 && !sum_ready));

    // R6: a captured word forces the ready flag low on the next cycle
    a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> !sum_ready);

    // R9: a ready, idle unit keeps its sums steady
    a_r9_settled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_ready && !clr && !cap) |=> $stable(sum_raw));

endmodule

// File: tb/sim_cks_snoop_top.sv
module sim_cks_snoop_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        bus_vld;
    logic [31:0] bus_data;
    logic        reg_wr;
    logic        reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [15:0] csum_out;
    logic        sum_ready;

    cks_snoop_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_data(bus_data),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .csum_out(csum_out), .sum_ready(sum_ready)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] m_hi, m_lo;
    bit   [63:0] m_tot;
    bit          m_en;

    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'b0, s[16]};
    endfunction

    function automatic logic [15:0] inet_csum(input bit [63:0] t);
        bit [63:0] v;
        v = t;
        while (v > 64'hFFFF) v = (v & 64'hFFFF) + (v >> 16);
        return ~v[15:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic m_clear();
        m_hi = '0; m_lo = '0; m_tot = '0;
    endtask

    task automatic m_add(input logic [31:0] w);
        m_hi  = oc_add(m_hi, w[31:16]);
        m_lo  = oc_add(m_lo, w[15:0]);
        m_tot = m_tot + w[31:16] + w[15:0];
    endtask

    task automatic reg_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 1'b1) m_clear();
        else m_en = d[0];
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        bus_vld = 1'b1; bus_data = w;
        if (m_en) m_add(w);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_vld = 1'b0;
    endtask

    task automatic wait_ready(input string req);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (sum_ready) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        chk(seen, req, {31'b0, sum_ready}, 32'd1);
    endtask

    task automatic check_sums(input string req);
        logic [31:0] v;
        reg_read(1'b1, v);
        chk(v == {m_hi, m_lo}, req, v, {m_hi, m_lo});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        logic [15:0] cs;
        void'($urandom(32'h1A2B3C4D));
        rst_n = 1'b0; bus_vld = 1'b0; bus_data = '0;
        reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
        m_en = 1'b0; m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        reg_read(1'b1, v);
        chk(v == 32'h0, "R12 sums", v, 32'h0);
        reg_read(1'b0, v);
        chk(v == 32'h0, "R12 enable", v, 32'h0);
        chk(sum_ready == 1'b1, "R12 ready", {31'b0, sum_ready}, 32'd1);
        chk(csum_out == 16'hFFFF, "R12 csum", {16'b0, csum_out}, 32'hFFFF);

        // R4: enable write and readback
        reg_write(1'b0, 32'hFFFF_FFFF);
        reg_read(1'b0, v);
        chk(v == 32'h1, "R4 enable readback", v, 32'h1);

        // R2: end-around carry within each half
        reg_write(1'b1, 32'h0);
        send(32'hFFFF_FFFF);
        send(32'h0001_0001);
        idle();
        wait_ready("R7 ready after wrap");
        check_sums("R2 wrap");
        chk(m_hi == 16'h0001 && m_lo == 16'h0001, "R2 model", {m_hi, m_lo}, 32'h0001_0001);

        // R1: no carry crosses from lower to upper or upper to lower
        reg_write(1'b1, 32'h0);
        send(32'h8000_0000);
        send(32'h8000_0000);
        send(32'h0000_8000);
        idle();
        wait_ready("R7 ready halves");
        check_sums("R1 halves independent");

        // R6: ready low through six samples after a capture
        reg_write(1'b1, 32'h0);
        send(32'h1234_5678);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            bus_vld = 1'b0;
            chk(sum_ready == 1'b0, "R6 drain window", {31'b0, sum_ready}, 32'd0);
        end
        wait_ready("R7 ready after drain");
        check_sums("R6 value after drain");

        // R9: reads do not disturb the sum
        reg_read(1'b1, v);
        reg_read(1'b0, v2);
        reg_read(1'b1, v2);
        reg_read(1'b1, v2);
        chk(v2 == v, "R9 repeated read", v2, v);

        // R4: disabled unit ignores transfers
        reg_write(1'b0, 32'h0);
        send(32'hDEAD_BEEF);
        send(32'h0F0F_F0F0);
        idle();
        repeat (8) @(negedge clk);
        check_sums("R4 disabled ignores bus");
        reg_write(1'b0, 32'h1);

        // R3: clear wins over a same-cycle bus word
        send(32'hAAAA_5555);
        @(negedge clk);
        bus_vld = 1'b1; bus_data = 32'h7777_3333;
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h0BAD_F00D;
        m_clear();
        @(negedge clk);
        bus_vld = 1'b0; reg_wr = 1'b0;
        chk(sum_ready == 1'b0, "R3 ready low after clear", {31'b0, sum_ready}, 32'd0);
        wait_ready("R7 ready after clear");
        check_sums("R3 clear zeroes");
        chk(csum_out == 16'hFFFF, "R3 csum after clear", {16'b0, csum_out}, 32'hFFFF);

        // R10: seed then data equals seed as data
        reg_write(1'b1, 32'h0);
        send(32'h1111_2222);
        send(32'h0F00_00F0);
        send(32'hFEDC_BA98);
        idle();
        wait_ready("R7 ready seed");
        check_sums("R10 seeded sums");
        chk(csum_out == inet_csum(m_tot), "R10 seeded csum", {16'b0, csum_out}, {16'b0, inet_csum(m_tot)});

        // R5, R8, R11: random packets with gaps and back-to-back words
        for (int p = 0; p < 10; p++) begin
            int len;
            reg_write(1'b1, 32'h0);
            len = 1 + int'($urandom % 40);
            for (int i = 0; i < len; i++) begin
                logic [31:0] w;
                w = $urandom;
                if (p == 0) w = 32'hFFFF_FFFF;
                if (i == 0 && w == 32'h0) w = 32'h1;
                if (p >= 2 && ($urandom % 4) == 0) idle();
                send(w);
            end
            idle();
            wait_ready("R7 ready packet");
            check_sums("R5 packet sums");
            chk(csum_out == inet_csum(m_tot), "R8 packet csum", {16'b0, csum_out}, {16'b0, inet_csum(m_tot)});
            cs = csum_out;
            send({16'h0, cs});
            idle();
            wait_ready("R7 ready verify");
            chk(csum_out == 16'h0000, "R11 resum zero", {16'b0, csum_out}, 32'h0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule